// File: doc/BRIEF.md
# SPI Slave Port with Host-Request Handshake

This block is a full-duplex SPI slave. One 24-bit shift register serves both directions. The outgoing word leaves on MISO, most significant bit first, while the incoming word enters from MOSI. A local processor places outgoing words in a transmit holding register. The block copies that register into the shift register only while no word is in flight. If the processor has written nothing since the last copy, the shift register keeps whatever it holds and sends it again on the next word. After a completed word, that is the word just received.

Received words go into a four-deep receive FIFO, which the local side reads through a show-ahead port. A host-request output lets an external master pace its transfers. It can signal that the receive path can accept a word, that a fresh transmit word has been loaded, or that both are true. It drops on the first leading clock edge of the next word.

All SPI pins are asynchronous to the system clock and pass through two-flop synchronizers before use. If the master releases slave select before the last bit, the partial word is discarded. Dropping the enable input is a full local reset of the port. Software must do this before it changes clock polarity, clock phase or request mode.

Top module: `spi_req_slave`

## Requirements
- R1: While `cfg_en` is low, one clock later and for as long as it stays low, `rx_nempty`, `host_req`, `overrun` and `tx_overwrite` are 0, `tx_empty` is 1, and the FIFO and shift register are cleared to empty and zero. `tx_wr` is ignored.
- R2: In all four combinations of `cfg_cpol` and `cfg_cpha`, each word shifts out on `miso` MSB first while the word on `mosi` is captured MSB first. With `cfg_cpha`=0 data is sampled on the leading SCK edge (rising when `cfg_cpol`=0). With `cfg_cpha`=1 it is sampled on the trailing edge.
- R3: A word written with `tx_wr` is copied into the shift register only while no word is in progress, and `tx_empty` returns to 1 at that copy. A write during a word leaves `tx_empty` at 0 until the word ends.
- R4: If no word has been written since the last copy, the next word sends the current shift-register contents: the previously received word, or zero after enable.
- R5: Every completed word is pushed into a 4-deep FIFO. `rx_nempty` is 1 while it holds data, `rx_data` shows the oldest word, and `rx_rd` removes it.
- R6: With `cfg_req_mode`=01, `host_req` is 1 when no word is in progress and the FIFO is not full.
- R7: With `cfg_req_mode`=10, `host_req` is 1 after the shift register has been loaded from the holding register and before the next word starts. A word without a new load leaves it at 0.
- R8: With `cfg_req_mode`=11, `host_req` is 1 only when both the mode-01 and mode-10 conditions hold. With 00, `host_req` stays 0.
- R9: `host_req` falls within two system clocks after the first leading SCK edge of a word is seen. A falling `ss_n` alone does not clear it.
- R10: If `ss_n` rises before the 24th sampling edge, the word is dropped, nothing enters the FIFO, and the bit count restarts.
- R11: A word that completes into a full FIFO is lost and sets the sticky `overrun` flag. If `rx_rd` pops in the same cycle, the word is accepted and `overrun` stays 0.
- R12: A `tx_wr` while the holding register is still full sets the sticky `tx_overwrite` flag, and the newer word replaces the older one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Port enable; low resets the port |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfg_req_mode | input | 2 | Host-request source: 00 off, 01 receive, 10 transmit, 11 both |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_data | input | 24 | Transmit word |
| rx_rd | input | 1 | Pop strobe for the receive FIFO |
| rx_data | output | 24 | Oldest received word |
| tx_empty | output | 1 | Holding register may be written |
| rx_nempty | output | 1 | Receive FIFO holds data |
| overrun | output | 1 | Sticky: a received word was lost |
| tx_overwrite | output | 1 | Sticky: holding register written while full |
| sck | input | 1 | SPI serial clock |
| mosi | input | 1 | SPI data from master |
| ss_n | input | 1 | SPI slave select, active low |
| miso | output | 1 | SPI data to master |
| host_req | output | 1 | Request output to the master |

## Verification
Two events can land in the same system clock. The first is the final sampling edge that pushes a word into a FIFO that is already full. The second is a local read that frees a slot. The bench fills the FIFO, then asserts `rx_rd` for exactly the cycle in which the synchronized last edge takes effect. It counts two synchronizer stages and the edge register to find that cycle. The result is judged by `overrun` staying clear and by the FIFO then yielding the four remaining words in arrival order, with the newest last.

// File: rtl/spi_req_pkg.sv
package spi_req_pkg;

    // Source selection for the host-request output
    typedef enum logic [1:0] {
        REQ_OFF  = 2'b00,
        REQ_RX   = 2'b01,
        REQ_TX   = 2'b10,
        REQ_BOTH = 2'b11
    } req_mode_e;

endpackage

// File: rtl/spi_req_sync.sv
module spi_req_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= din;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/spi_req_fifo.sv
module spi_req_fifo #(
    parameter int WIDTH = 24,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full
);

    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0]   wp;
        logic [AW-1:0]   rp;
        logic [CNTW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t         q, d;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic             do_push, do_pop;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (q.cnt == CNTW'(DEPTH));
    assign empty   = (q.cnt == '0);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign rdata   = mem_q[q.rp];

    always_comb begin
        d = q;
        if (clr) begin
            d = '0;
        end else begin
            if (do_push) d.wp = ptr_inc(q.wp);
            if (do_pop)  d.rp = ptr_inc(q.rp);
            case ({do_push, do_pop})
                2'b10:   d.cnt = q.cnt + 1'b1;
                2'b01:   d.cnt = q.cnt - 1'b1;
                default: d.cnt = q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem_q[q.wp] <= wdata;
    end

    // R5
    fifo_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !full && !clr) |=> (q.cnt == $past(q.cnt) + CNTW'(1)));

    // R11
    fifo_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && full && !clr) |=> full);

endmodule

// File: rtl/spi_req_slave.sv
module spi_req_slave
    import spi_req_pkg::*;
#(
    parameter int WORD_W      = 24,
    parameter int FIFO_DEPTH  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic [1:0]        cfg_req_mode,
    input  logic              tx_wr,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              rx_rd,
    output logic [WORD_W-1:0] rx_data,
    output logic              tx_empty,
    output logic              rx_nempty,
    output logic              overrun,
    output logic              tx_overwrite,
    input  logic              sck,
    input  logic              mosi,
    input  logic              ss_n,
    output logic              miso,
    output logic              host_req
);

    localparam int              CW       = $clog2(WORD_W);
    localparam logic [CW-1:0]   LAST_BIT = CW'(WORD_W - 1);

    typedef struct packed {
        logic [WORD_W-1:0] sr;        // shared shift register
        logic [WORD_W-1:0] txh;       // transmit holding register
        logic              txh_full;
        logic [CW-1:0]     bits;      // sampled bits of current word
        logic              act;       // word in progress
        logic              loaded;    // fresh load not yet consumed
        logic              sck_prev;
        logic              ovr;
        logic              wov;
        logic              hreq;
    } slave_st_t;

    slave_st_t         q, d;
    logic              sck_s, mosi_s, ss_s;
    logic              rise, fall, lead, trail, sel, samp, load;
    logic              push, fifo_full, fifo_empty, fifo_pop;
    logic [WORD_W-1:0] push_word;
    logic              rx_ok, tx_ok;

    spi_req_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b001)
    ) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sck, mosi, ss_n}),
        .dout ({sck_s, mosi_s, ss_s})
    );

    // Edge classification from the synchronized clock
    assign rise      = sck_s && !q.sck_prev;
    assign fall      = !sck_s && q.sck_prev;
    assign lead      = cfg_cpol ? fall : rise;
    assign trail     = cfg_cpol ? rise : fall;
    assign sel       = !ss_s;
    assign samp      = sel && (cfg_cpha ? trail : lead);
    assign load      = cfg_en && q.txh_full && !q.act && !(sel && lead);
    assign push_word = {q.sr[WORD_W-2:0], mosi_s};
    assign rx_ok     = !q.act && !fifo_full;
    assign tx_ok     = q.loaded;
    assign fifo_pop  = rx_rd && cfg_en;

    always_comb begin
        d          = q;
        push       = 1'b0;
        d.sck_prev = sck_s;
        if (!cfg_en) begin
            d          = '0;
            d.sck_prev = sck_s;
        end else begin
            if (!sel) begin
                d.bits = '0;
                d.act  = 1'b0;
            end else begin
                if (lead) d.act = 1'b1;
                if (samp) begin
                    d.sr = push_word;
                    if (q.bits == LAST_BIT) begin
                        d.bits = '0;
                        d.act  = 1'b0;
                        push   = 1'b1;
                    end else begin
                        d.bits = q.bits + 1'b1;
                    end
                end
            end
            if (load) begin
                d.sr       = q.txh;
                d.txh_full = 1'b0;
                d.loaded   = 1'b1;
            end
            if (sel && lead && !q.act) d.loaded = 1'b0;
            if (tx_wr) begin
                if (q.txh_full && !load) d.wov = 1'b1;
                d.txh      = tx_data;
                d.txh_full = 1'b1;
            end
            if (push && fifo_full && !rx_rd) d.ovr = 1'b1;
            case (req_mode_e'(cfg_req_mode))
                REQ_RX:   d.hreq = rx_ok;
                REQ_TX:   d.hreq = tx_ok;
                REQ_BOTH: d.hreq = rx_ok && tx_ok;
                default:  d.hreq = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    spi_req_fifo #(
        .WIDTH(WORD_W),
        .DEPTH(FIFO_DEPTH)
    ) i_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (!cfg_en),
        .push (push),
        .wdata(push_word),
        .pop  (fifo_pop),
        .rdata(rx_data),
        .empty(fifo_empty),
        .full (fifo_full)
    );

    assign miso         = q.sr[WORD_W-1];
    assign host_req     = q.hreq;
    assign tx_empty     = !q.txh_full;
    assign rx_nempty    = !fifo_empty;
    assign overrun      = q.ovr;
    assign tx_overwrite = q.wov;

    // R1
    en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> (!host_req && tx_empty && !rx_nempty && !overrun && !tx_overwrite));

    // R3
    load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && q.act && q.txh_full) |=> !tx_empty);

    // R9
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.act) |=> !host_req);

    // R10
    abort_nopush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ss_s |-> !push);

    // R11
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && cfg_en) |=> overrun);

    // R12
    wov_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_overwrite && cfg_en) |=> tx_overwrite);

endmodule

// File: tb/test_spi_req_slave.sv
module test_spi_req_slave;

    localparam int W = 24;
    localparam int H = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_en = 1'b0, cfg_cpol = 1'b0, cfg_cpha = 1'b0;
    logic [1:0]    cfg_req_mode = 2'b00;
    logic          tx_wr = 1'b0, rx_rd = 1'b0;
    logic [W-1:0]  tx_data = '0;
    logic [W-1:0]  rx_data;
    logic          tx_empty, rx_nempty, overrun, tx_overwrite;
    logic          sck = 1'b0, mosi = 1'b0, ss_n = 1'b1;
    logic          miso, host_req;

    always #10 clk = ~clk;

    spi_req_slave i_spi_req_slave (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_cpol(cfg_cpol),
        .cfg_cpha(cfg_cpha), .cfg_req_mode(cfg_req_mode), .tx_wr(tx_wr),
        .tx_data(tx_data), .rx_rd(rx_rd), .rx_data(rx_data), .tx_empty(tx_empty),
        .rx_nempty(rx_nempty), .overrun(overrun), .tx_overwrite(tx_overwrite),
        .sck(sck), .mosi(mosi), .ss_n(ss_n), .miso(miso), .host_req(host_req)
    );

    int           checks = 0;
    int           fails = 0;
    bit           done = 0;
    logic         cpol_b = 0, cpha_b = 0;
    logic [W-1:0] nxt_m = '0;
    logic [W-1:0] mq[$];
    bit           ovr_m = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit fifo_accepts(input int depth_now, input bit popping);
        return (depth_now < 4) || popping;
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(input logic p, input logic h, input logic [1:0] m);
        cfg_en = 0; ss_n = 1;
        cyc(2);
        cfg_cpol = p; cfg_cpha = h; cfg_req_mode = m; sck = p;
        cpol_b = p; cpha_b = h;
        cyc(4);
        cfg_en = 1;
        cyc(3);
        nxt_m = '0; mq.delete(); ovr_m = 0;
    endtask

    task automatic wr_tx(input logic [W-1:0] w);
        tx_data = w; tx_wr = 1;
        cyc(1);
        tx_wr = 0;
        nxt_m = w;
    endtask

    task automatic xfer(input logic [W-1:0] mo, input int nbits, input bit pop_last,
                        output logic [W-1:0] mi, output logic [W-1:0] popped);
        mi = '0; popped = '0;
        ss_n = 0;
        cyc(H);
        for (int i = 0; i < nbits; i++) begin
            if (!cpha_b) begin
                mosi = mo[W-1-i];
                cyc(H);
                mi[W-1-i] = miso;
                sck = ~cpol_b;
            end else begin
                cyc(H);
                sck = ~cpol_b;
                mosi = mo[W-1-i];
                cyc(H);
                mi[W-1-i] = miso;
                sck = cpol_b;
            end
            if (pop_last && i == nbits - 1) begin
                @(posedge clk); @(posedge clk); @(negedge clk);
                popped = rx_data; rx_rd = 1;
                @(negedge clk);
                rx_rd = 0;
            end
            if (!cpha_b) begin
                cyc(H);
                sck = cpol_b;
            end
        end
        cyc(H);
        ss_n = 1;
        cyc(6);
    endtask

    task automatic word(input logic [W-1:0] mo, input string req);
        logic [W-1:0] mi, pd;
        xfer(mo, W, 0, mi, pd);
        chk(mi == nxt_m, req, mi, nxt_m);
        if (fifo_accepts(mq.size(), 0)) mq.push_back(mo);
        else ovr_m = 1;
        nxt_m = mo;
    endtask

    task automatic rd_check(input string req);
        logic [W-1:0] got, exp;
        if (mq.size() == 0) begin
            chk(rx_nempty == 0, req, rx_nempty, 0);
        end else begin
            chk(rx_nempty == 1, req, rx_nempty, 1);
            got = rx_data; rx_rd = 1;
            cyc(1);
            rx_rd = 0;
            exp = mq.pop_front();
            chk(got == exp, req, got, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] mi, pd, a, b;
        void'($urandom(32'h5EED_0042));
        cyc(3);
        rst_n = 1;
        cyc(2);

        // R1 reset state with the port disabled
        chk(tx_empty == 1, "R1", tx_empty, 1);
        chk(rx_nempty == 0, "R1", rx_nempty, 0);
        chk(host_req == 0, "R1", host_req, 0);
        chk(overrun == 0 && tx_overwrite == 0, "R1", {overrun, tx_overwrite}, 0);

        // Directed: load, exchange, echo
        set_mode(0, 0, 2'b01);
        chk(host_req == 1, "R6", host_req, 1);
        wr_tx(24'hA5C3_0F);
        cyc(2);
        chk(tx_empty == 1, "R3", tx_empty, 1);
        word(24'h123456, "R2");
        rd_check("R5");
        word(24'hFEDCBA, "R4");
        rd_check("R5");

        // Random traffic over all clock modes
        for (int m = 0; m < 4; m++) begin
            set_mode(m[1], m[0], 2'b01);
            for (int k = 0; k < 10; k++) begin
                if ($urandom % 2) wr_tx(24'($urandom));
                word(24'($urandom), "R2");
                if ($urandom % 10 < 6) rd_check("R5");
                chk(overrun == ovr_m, "R11", overrun, ovr_m);
            end
            while (mq.size() > 0) rd_check("R5");
        end

        // Overwrite while a word is in flight
        set_mode(0, 0, 2'b01);
        wr_tx(24'h111111);
        cyc(2);
        a = nxt_m;
        fork
            xfer(24'h0F0F0F, W, 0, mi, pd);
            begin
                cyc(60);
                wr_tx(24'h222222);
                wr_tx(24'h333333);
                chk(tx_empty == 0, "R3", tx_empty, 0);
                chk(tx_overwrite == 1, "R12", tx_overwrite, 1);
            end
        join
        chk(mi == a, "R2", mi, a);
        mq.push_back(24'h0F0F0F);
        cyc(2);
        chk(tx_empty == 1, "R3", tx_empty, 1);
        word(24'h445566, "R12");
        rd_check("R5"); rd_check("R5");

        // Transmit-request mode and deassertion on the first edge
        set_mode(0, 0, 2'b10);
        chk(host_req == 0, "R7", host_req, 0);
        wr_tx(24'hC0FFEE);
        cyc(2);
        chk(host_req == 1, "R7", host_req, 1);
        fork
            word(24'h777777, "R2");
            begin
                cyc(H + 2);
                chk(host_req == 1, "R9", host_req, 1);
                cyc(8);
                chk(host_req == 0, "R9", host_req, 0);
            end
        join
        chk(host_req == 0, "R7", host_req, 0);

        // Receive-request mode, full FIFO and overrun
        set_mode(1, 1, 2'b01);
        chk(host_req == 1, "R6", host_req, 1);
        for (int k = 0; k < 4; k++) word(24'($urandom), "R2");
        chk(host_req == 0, "R6", host_req, 0);
        word(24'hBADBAD, "R4");
        chk(overrun == 1, "R11", overrun, 1);
        for (int k = 0; k < 4; k++) rd_check("R11");
        cyc(2);
        chk(host_req == 1, "R6", host_req, 1);
        chk(overrun == 1, "R11", overrun, 1);

        // Both-conditions mode, then push and pop in the same cycle
        set_mode(0, 1, 2'b11);
        chk(host_req == 0, "R8", host_req, 0);
        wr_tx(24'h010203);
        cyc(2);
        chk(host_req == 1, "R8", host_req, 1);
        for (int k = 0; k < 4; k++) begin
            wr_tx(24'($urandom));
            cyc(2);
            word(24'($urandom), "R2");
        end
        wr_tx(24'h0A0B0C);
        cyc(2);
        chk(host_req == 0, "R8", host_req, 0);
        b = 24'h5A5A5A;
        xfer(b, W, 1, mi, pd);
        chk(mi == nxt_m, "R2", mi, nxt_m);
        a = mq.pop_front();
        chk(pd == a, "R11", pd, a);
        mq.push_back(b);
        nxt_m = b;
        chk(overrun == 0, "R11", overrun, 0);
        for (int k = 0; k < 4; k++) rd_check("R11");

        // Request mode off
        set_mode(0, 0, 2'b00);
        wr_tx(24'h999999);
        cyc(2);
        chk(host_req == 0, "R8", host_req, 0);

        // Early slave-select release
        set_mode(0, 1, 2'b01);
        wr_tx(24'h13579B);
        cyc(2);
        xfer(24'hFFFFFF, 10, 0, mi, pd);
        chk(rx_nempty == 0, "R10", rx_nempty, 0);
        wr_tx(24'h2468AC);
        cyc(2);
        word(24'h3C3C3C, "R10");
        rd_check("R10");
        rd_check("R10");

        // Enable drop clears everything
        set_mode(1, 0, 2'b01);
        for (int k = 0; k < 5; k++) word(24'($urandom), "R2");
        chk(overrun == 1, "R11", overrun, 1);
        cfg_en = 0;
        cyc(2);
        chk(rx_nempty == 0 && overrun == 0, "R1", {rx_nempty, overrun}, 0);
        chk(tx_empty == 1 && host_req == 0, "R1", {tx_empty, host_req}, 2);
        cfg_en = 1;
        cyc(3);
        nxt_m = '0; mq.delete(); ovr_m = 0;
        chk(rx_nempty == 0, "R1", rx_nempty, 0);
        word(24'h6B6B6B, "R4");
        rd_check("R5");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule